// File: doc/BRIEF.md
# Page Translation Buffer with Read and Execute Inhibit

This block is a small, fully associative translation buffer that software fills and inspects directly. Each of its entries covers an aligned pair of neighbouring pages (an even page and an odd page) of a 32-bit virtual address space. The entry holds one virtual page number, an address-space identifier (ASID), a page-size mask and a global flag. Each page of the pair has its own frame number, cache attribute, valid flag, dirty (writable) flag, read-inhibit flag and execute-inhibit flag. Per-page policies such as no-read, no-execute and read-only are built from these flags.

Software writes an entry through a plain write port. The port takes the tag fields and two page-descriptor words, one per half. A plain combinational read port returns the tag and rebuilds both descriptor words from an entry. Translation requests arrive on a valid/ready stream carrying a virtual address, an ASID and an access kind. Each request produces one registered response: a physical address, or exactly one fault code. The response stage holds a single result. `req_ready` is high when that stage is empty or when its result is being taken in the same cycle (`!rsp_valid || rsp_ready`). A response that is not taken stays unchanged until `rsp_ready` is seen high.

Top module: `tlb_rixi_top`

## Requirements
- R1: Descriptor word layout, bit 0 first: bit 0 global, bit 1 valid, bit 2 dirty, bits 5:3 cache attribute, bits 29:6 frame number, bit 30 execute-inhibit, bit 31 read-inhibit. A write stores bits 31:1 of each word for its half. The entry's global flag is the AND of bit 0 of both words. On read-back, both words carry their stored bits 31:1 and that single global flag in bit 0. The read-back tag returns the written page number, ASID and mask.
- R2: An entry matches when the virtual address bits 31:13, excluding those set in the page mask (mask bit k covers address bit 13+k), equal the stored page number, and the entry is global or its ASID equals the request ASID. With no match, the fault is NOMATCH. Fault codes: 0 none, 1 NOMATCH, 2 INVALID, 3 DIRTY, 4 read-inhibit, 5 execute-inhibit.
- R3: The half is selected by one address bit: the highest bit of the offset mask {page mask, 13 ones}. That bit is address bit 12 for a zero page mask, and bit 13+k for a page mask of k+1 low ones. The page mask must be of the form 2^n-1.
- R4: On success, the 36-bit physical address is the selected frame number shifted left by 12, ORed with the address bits under the offset mask shifted right by one. On any fault, the physical address is 0.
- R5: A matched half with valid clear gives INVALID for every access kind, ahead of all other checks.
- R6: Access kinds: 0 fetch, 1 load, 2 store. A fetch to a valid half with execute-inhibit set gives the execute-inhibit fault. A fetch to a valid, execute-permitted half succeeds whatever its dirty and read-inhibit flags are.
- R7: A load to a valid half with read-inhibit set gives the read-inhibit fault. A load ignores execute-inhibit and dirty.
- R8: A store to a valid half with dirty clear gives DIRTY. A store ignores read-inhibit and execute-inhibit.
- R9: A request accepted at an edge (`req_valid && req_ready`) gives `rsp_valid` after that edge. While `rsp_valid && !rsp_ready`, the response holds and `req_ready` is low.
- R10: Reset clears every entry to zero and drops `rsp_valid`. A lookup of address 0 with ASID 0 then matches entry 0 and returns INVALID.
- R11: A write is visible to a lookup or a read-back in the cycle after its edge. When several entries match, the lowest index decides the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write the entry at wr_idx |
| wr_idx | input | 3 | Entry written |
| wr_vpn | input | 19 | Virtual page number (address bits 31:13) |
| wr_asid | input | 8 | ASID of the entry |
| wr_pmask | input | 16 | Page mask (covers address bits 28:13) |
| wr_lo0 | input | 32 | Descriptor word, even half |
| wr_lo1 | input | 32 | Descriptor word, odd half |
| rd_idx | input | 3 | Entry read back |
| rd_vpn | output | 19 | Stored page number |
| rd_asid | output | 8 | Stored ASID |
| rd_pmask | output | 16 | Stored page mask |
| rd_lo0 | output | 32 | Rebuilt even descriptor word |
| rd_lo1 | output | 32 | Rebuilt odd descriptor word |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request accepted this cycle |
| req_va | input | 32 | Virtual address |
| req_asid | input | 8 | Requesting ASID |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken this cycle |
| rsp_fault | output | 3 | Fault code, 0 when translated |
| rsp_pa | output | 36 | Physical address, 0 on a fault |

## Verification
Every cycle, the assertions check four things. A response holds still under back-pressure, and a new response appears only after an accepted request. Each inhibit or dirty fault agrees with the access kind that raised it, and faults carry a zero address. A read-back right after a write returns that write with the combined global flag. Other behaviour only shows in the bench's scenarios against its reference model. This covers the actual frame and offset arithmetic, the half selection for each page size, the order of the checks on one page, ASID and global matching, and lowest-index resolution. The scenarios include directed policy pages and a randomly filled buffer.

// File: rtl/tlb_rixi_pkg.sv
package tlb_rixi_pkg;

  localparam int VA_W      = 32;
  localparam int LO_W      = 32;
  localparam int PAGE_SH   = 12;
  localparam int VPN_LSB   = 13;
  localparam int VPN_W     = VA_W - VPN_LSB;
  localparam int PM_W      = 16;
  localparam int PFN_LSB   = 6;
  localparam int PFN_W     = 24;
  localparam int CA_W      = 3;
  localparam int PA_W      = PFN_W + PAGE_SH;
  localparam int RINH_BIT  = 31;
  localparam int XINH_BIT  = 30;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_NOMATCH = 3'd1,
    FLT_INVALID = 3'd2,
    FLT_DIRTY   = 3'd3,
    FLT_RINH    = 3'd4,
    FLT_XINH    = 3'd5
  } flt_e;

  // one half (page) of an entry
  typedef struct packed {
    logic             rinh;
    logic             xinh;
    logic [PFN_W-1:0] pfn;
    logic [CA_W-1:0]  cattr;
    logic             dirty;
    logic             valid;
  } page_t;

  function automatic page_t lo_to_page(input logic [LO_W-1:0] lo);
    page_t p;
    p.rinh  = lo[RINH_BIT];
    p.xinh  = lo[XINH_BIT];
    p.pfn   = lo[PFN_LSB +: PFN_W];
    p.cattr = lo[3 +: CA_W];
    p.dirty = lo[2];
    p.valid = lo[1];
    return p;
  endfunction

  function automatic logic [LO_W-1:0] page_to_lo(input page_t p, input logic g);
    logic [LO_W-1:0] lo;
    lo = '0;
    lo[RINH_BIT]         = p.rinh;
    lo[XINH_BIT]         = p.xinh;
    lo[PFN_LSB +: PFN_W] = p.pfn;
    lo[3 +: CA_W]        = p.cattr;
    lo[2]                = p.dirty;
    lo[1]                = p.valid;
    lo[0]                = g;
    return lo;
  endfunction

endpackage

// File: rtl/tlb_entry_bank.sv
module tlb_entry_bank
  import tlb_rixi_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PM_W-1:0]   wr_pmask,
  input  logic [LO_W-1:0]   wr_lo0,
  input  logic [LO_W-1:0]   wr_lo1,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [VPN_W-1:0]  rd_vpn,
  output logic [ASID_W-1:0] rd_asid,
  output logic [PM_W-1:0]   rd_pmask,
  output logic [LO_W-1:0]   rd_lo0,
  output logic [LO_W-1:0]   rd_lo1,
  output logic [VPN_W-1:0]  ent_vpn   [ENTRIES],
  output logic [ASID_W-1:0] ent_asid  [ENTRIES],
  output logic [PM_W-1:0]   ent_pmask [ENTRIES],
  output logic              ent_glob  [ENTRIES],
  output page_t             ent_even  [ENTRIES],
  output page_t             ent_odd   [ENTRIES]
);

  page_t wr_even, wr_odd;
  logic  wr_glob;

  assign wr_even = lo_to_page(wr_lo0);
  assign wr_odd  = lo_to_page(wr_lo1);
  assign wr_glob = wr_lo0[0] & wr_lo1[0];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic hit_wr;
    assign hit_wr = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_vpn[e]   <= '0;
        ent_asid[e]  <= '0;
        ent_pmask[e] <= '0;
        ent_glob[e]  <= 1'b0;
        ent_even[e]  <= '0;
        ent_odd[e]   <= '0;
      end else if (hit_wr) begin
        ent_vpn[e]   <= wr_vpn;
        ent_asid[e]  <= wr_asid;
        ent_pmask[e] <= wr_pmask;
        ent_glob[e]  <= wr_glob;
        ent_even[e]  <= wr_even;
        ent_odd[e]   <= wr_odd;
      end
    end
  end

  always_comb begin
    rd_vpn   = ent_vpn[rd_idx];
    rd_asid  = ent_asid[rd_idx];
    rd_pmask = ent_pmask[rd_idx];
    rd_lo0   = page_to_lo(ent_even[rd_idx], ent_glob[rd_idx]);
    rd_lo1   = page_to_lo(ent_odd[rd_idx], ent_glob[rd_idx]);
  end

endmodule

// File: rtl/tlb_tag_match.sv
module tlb_tag_match
  import tlb_rixi_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [VPN_W-1:0]  va_vpn,
  input  logic [ASID_W-1:0] asid,
  input  logic [VPN_W-1:0]  ent_vpn   [ENTRIES],
  input  logic [ASID_W-1:0] ent_asid  [ENTRIES],
  input  logic [PM_W-1:0]   ent_pmask [ENTRIES],
  input  logic              ent_glob  [ENTRIES],
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);

  localparam int PAD_W = VPN_W - PM_W;

  logic [ENTRIES-1:0] hit_vec;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    logic [VPN_W-1:0] care;
    logic             tag_eq;
    logic             asid_ok;
    assign care    = ~{{PAD_W{1'b0}}, ent_pmask[e]};
    assign tag_eq  = ((va_vpn ^ ent_vpn[e]) & care) == '0;
    assign asid_ok = ent_glob[e] || (ent_asid[e] == asid);
    assign hit_vec[e] = tag_eq && asid_ok;
  end

  // lowest index wins: scan downwards so the last assignment is the lowest
  always_comb begin
    hit     = |hit_vec;
    hit_idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (hit_vec[e]) hit_idx = IDX_W'(e);
    end
  end

endmodule

// File: rtl/tlb_perm_eval.sv
module tlb_perm_eval
  import tlb_rixi_pkg::*;
(
  input  logic            hit,
  input  logic [VA_W-1:0] va,
  input  logic [1:0]      acc,
  input  logic [PM_W-1:0] pmask,
  input  page_t           even,
  input  page_t           odd,
  output logic [2:0]      fault,
  output logic [PA_W-1:0] pa
);

  localparam int TOP_PAD = VA_W - PM_W - VPN_LSB;

  logic [VA_W-1:0] off_mask;
  logic [VA_W-1:0] low_mask;
  logic            odd_sel;
  page_t           pg;
  flt_e            flt;
  acc_e            kind;

  assign off_mask = {{TOP_PAD{1'b0}}, pmask, {VPN_LSB{1'b1}}};
  assign low_mask = off_mask >> 1;
  assign odd_sel  = |(va & off_mask & ~low_mask);
  assign pg       = odd_sel ? odd : even;
  assign kind     = acc_e'(acc);

  // fixed order: match, valid, execute-inhibit, read-inhibit, dirty
  always_comb begin
    if (!hit)                                flt = FLT_NOMATCH;
    else if (!pg.valid)                      flt = FLT_INVALID;
    else if (kind == ACC_FETCH && pg.xinh)   flt = FLT_XINH;
    else if (kind == ACC_LOAD  && pg.rinh)   flt = FLT_RINH;
    else if (kind == ACC_STORE && !pg.dirty) flt = FLT_DIRTY;
    else                                     flt = FLT_NONE;
  end

  assign fault = flt;
  assign pa    = (flt == FLT_NONE)
               ? ({pg.pfn, {PAGE_SH{1'b0}}} | {{(PA_W-VA_W){1'b0}}, va & low_mask})
               : '0;

endmodule

// File: rtl/tlb_rixi_top.sv
module tlb_rixi_top
  import tlb_rixi_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [18:0]       wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [15:0]       wr_pmask,
  input  logic [31:0]       wr_lo0,
  input  logic [31:0]       wr_lo1,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [18:0]       rd_vpn,
  output logic [ASID_W-1:0] rd_asid,
  output logic [15:0]       rd_pmask,
  output logic [31:0]       rd_lo0,
  output logic [31:0]       rd_lo1,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_va,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [1:0]        req_acc,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_fault,
  output logic [35:0]       rsp_pa
);

  logic [VPN_W-1:0]  ent_vpn   [ENTRIES];
  logic [ASID_W-1:0] ent_asid  [ENTRIES];
  logic [PM_W-1:0]   ent_pmask [ENTRIES];
  logic              ent_glob  [ENTRIES];
  page_t             ent_even  [ENTRIES];
  page_t             ent_odd   [ENTRIES];

  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [2:0]        nxt_fault;
  logic [PA_W-1:0]   nxt_pa;

  tlb_entry_bank #(.ENTRIES(ENTRIES), .ASID_W(ASID_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_asid(wr_asid),
    .wr_pmask(wr_pmask), .wr_lo0(wr_lo0), .wr_lo1(wr_lo1),
    .rd_idx(rd_idx), .rd_vpn(rd_vpn), .rd_asid(rd_asid), .rd_pmask(rd_pmask),
    .rd_lo0(rd_lo0), .rd_lo1(rd_lo1),
    .ent_vpn(ent_vpn), .ent_asid(ent_asid), .ent_pmask(ent_pmask),
    .ent_glob(ent_glob), .ent_even(ent_even), .ent_odd(ent_odd)
  );

  tlb_tag_match #(.ENTRIES(ENTRIES), .ASID_W(ASID_W)) u_match (
    .va_vpn(req_va[VA_W-1:VPN_LSB]), .asid(req_asid),
    .ent_vpn(ent_vpn), .ent_asid(ent_asid), .ent_pmask(ent_pmask),
    .ent_glob(ent_glob), .hit(hit), .hit_idx(hit_idx)
  );

  tlb_perm_eval u_perm (
    .hit(hit), .va(req_va), .acc(req_acc),
    .pmask(ent_pmask[hit_idx]), .even(ent_even[hit_idx]), .odd(ent_odd[hit_idx]),
    .fault(nxt_fault), .pa(nxt_pa)
  );

  // single-entry response stage
  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= '0;
      rsp_pa    <= '0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault <= nxt_fault;
        rsp_pa    <= nxt_pa;
      end
    end
  end

endmodule

// File: rtl/tlb_rixi_checker.sv
module tlb_rixi_checker #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [31:0]      wr_lo0,
  input logic [31:0]      wr_lo1,
  input logic [IDX_W-1:0] rd_idx,
  input logic [31:0]      rd_lo0,
  input logic [31:0]      rd_lo1,
  input logic             req_valid,
  input logic             req_ready,
  input logic [1:0]       req_acc,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [2:0]       rsp_fault,
  input logic [35:0]      rsp_pa
);

  logic [1:0] held_acc;

  always_ff @(posedge clk) begin
    if (!rst_n)                     held_acc <= 2'd0;
    else if (req_valid && req_ready) held_acc <= req_acc;
  end

  assert_hold_under_backpressure_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_fault) && $stable(rsp_pa));

  assert_rsp_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready));

  assert_xinh_only_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == 3'd5 |-> held_acc == 2'd0);

  assert_rinh_only_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == 3'd4 |-> held_acc == 2'd1);

  assert_dirty_only_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == 3'd3 |-> held_acc == 2'd2);

  assert_fault_zero_pa_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 3'd0 |-> rsp_pa == 36'd0);

  assert_readback_after_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_idx != $past(wr_idx)) ||
              (rd_lo0[31:1] == $past(wr_lo0[31:1]) && rd_lo1[31:1] == $past(wr_lo1[31:1]) &&
               rd_lo0[0] == $past(wr_lo0[0] & wr_lo1[0]) && rd_lo1[0] == rd_lo0[0]));

endmodule

bind tlb_rixi_top tlb_rixi_checker #(.ENTRIES(ENTRIES)) u_chk (.*);

// File: tb/tlb_rixi_top_test.sv
module tlb_rixi_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [18:0] wr_vpn = '0;
  logic [7:0]  wr_asid = '0;
  logic [15:0] wr_pmask = '0;
  logic [31:0] wr_lo0 = '0, wr_lo1 = '0;
  logic [2:0]  rd_idx = '0;
  logic [18:0] rd_vpn;
  logic [7:0]  rd_asid;
  logic [15:0] rd_pmask;
  logic [31:0] rd_lo0, rd_lo1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [7:0]  req_asid = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [2:0]  rsp_fault;
  logic [35:0] rsp_pa;

  int n_cmp = 0;
  int n_bad = 0;

  logic [18:0] m_vpn  [8];
  logic [7:0]  m_asid [8];
  logic [15:0] m_pm   [8];
  logic [31:0] m_lo0  [8];
  logic [31:0] m_lo1  [8];

  always #5 clk = ~clk;

  tlb_rixi_top uut (.*);

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    summary();
  end

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model built from the requirements
  function automatic void model(input logic [31:0] va, input logic [7:0] asid, input logic [1:0] acc,
                                output logic [2:0] f, output logic [35:0] pa);
    logic found = 1'b0;
    f = 3'd1; pa = '0;
    for (int i = 0; i < 8; i++) begin
      logic [18:0] care = ~{3'b0, m_pm[i]};
      logic glob = m_lo0[i][0] & m_lo1[i][0];
      if (!found && ((va[31:13] & care) == (m_vpn[i] & care)) && (glob || m_asid[i] == asid)) begin
        logic [31:0] om = {3'b0, m_pm[i], 13'h1fff};
        logic [31:0] lo = ((va & om & ~(om >> 1)) != 0) ? m_lo1[i] : m_lo0[i];
        found = 1'b1;
        if (!lo[1])                   f = 3'd2;
        else if (acc == 0 && lo[30])  f = 3'd5;
        else if (acc == 1 && lo[31])  f = 3'd4;
        else if (acc == 2 && !lo[2])  f = 3'd3;
        else begin
          f = 3'd0;
          pa = {lo[29:6], 12'h000} | {4'h0, va & (om >> 1)};
        end
      end
    end
  endfunction

  task automatic write_entry(input logic [2:0] idx, input logic [18:0] vpn, input logic [7:0] asid,
                             input logic [15:0] pm, input logic [31:0] lo0, input logic [31:0] lo1,
                             input bit verify);
    logic g;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_asid = asid; wr_pmask = pm;
    wr_lo0 = lo0; wr_lo1 = lo1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    m_vpn[idx] = vpn; m_asid[idx] = asid; m_pm[idx] = pm; m_lo0[idx] = lo0; m_lo1[idx] = lo1;
    if (verify) begin
      g = lo0[0] & lo1[0];
      rd_idx = idx;
      #1;
      check("R1", "readback lo0", rd_lo0, {lo0[31:1], g});
      check("R1", "readback lo1", rd_lo1, {lo1[31:1], g});
      check("R1", "readback tag", {rd_vpn, rd_asid, rd_pmask}, {vpn, asid, pm});
    end
  endtask

  task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input logic [1:0] acc, input string req);
    logic [2:0]  ef;
    logic [35:0] ep;
    model(va, asid, acc, ef, ep);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_asid = asid; req_acc = acc; rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req, "rsp_valid", rsp_valid, 1'b1);
    check(req, "fault", rsp_fault, ef);
    check(req, "pa", rsp_pa, ep);
  endtask

  function automatic logic [31:0] mk_lo(input bit ri, input bit xi, input logic [23:0] pfn,
                                        input bit d, input bit v, input bit g);
    return {ri, xi, pfn, 3'd3, d, v, g};
  endfunction

  initial begin
    void'($urandom(32'h1d5ee0));
    for (int i = 0; i < 8; i++) begin
      m_vpn[i] = '0; m_asid[i] = '0; m_pm[i] = '0; m_lo0[i] = '0; m_lo1[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check("R10", "rsp_valid after reset", rsp_valid, 1'b0);
    check("R10", "req_ready after reset", req_ready, 1'b1);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      rd_idx = 3'(i);
      #1;
      check("R10", "cleared entry", {rd_lo0, rd_lo1, rd_vpn, rd_asid, rd_pmask}, '0);
    end
    lookup(32'h0, 8'h0, 2'd1, "R10");

    // entry 0: small pages, even no-execute, odd invalid
    write_entry(3'd0, 19'h00100, 8'h05, 16'h0, mk_lo(0, 1, 24'h000abc, 1, 1, 0),
                mk_lo(0, 0, 24'h000def, 1, 0, 0), 1'b1);
    lookup(32'h0020_0123, 8'h05, 2'd0, "R6");     // fetch -> execute-inhibit
    lookup(32'h0020_0123, 8'h05, 2'd1, "R7");     // load ignores XI
    lookup(32'h0020_0456, 8'h05, 2'd2, "R8");     // store ok, dirty set
    lookup(32'h0020_1123, 8'h05, 2'd0, "R5");     // odd half invalid
    lookup(32'h0020_0123, 8'h06, 2'd1, "R2");     // ASID mismatch

    // entry 1: global, 16 KB pages (mask 3), top offset bit 14 selects the half
    write_entry(3'd1, 19'h00200, 8'h11, 16'h3, mk_lo(1, 0, 24'h012340, 0, 1, 1),
                mk_lo(1, 1, 24'h056780, 1, 1, 1), 1'b1);
    lookup(32'h0040_2abc, 8'h77, 2'd1, "R7");     // even: read-inhibit
    lookup(32'h0040_2abc, 8'h77, 2'd2, "R8");     // even: dirty clear
    lookup(32'h0040_3abc, 8'h77, 2'd0, "R6");     // even fetch, dirty clear: ok
    lookup(32'h0040_7abc, 8'h77, 2'd2, "R8");     // odd: store ignores RI and XI
    lookup(32'h0040_6abc, 8'h01, 2'd0, "R3");     // odd fetch -> XI
    lookup(32'h0040_3fff, 8'h77, 2'd0, "R4");     // offset bits under mask>>1

    // entry 2: only one G bit set -> not global
    write_entry(3'd2, 19'h00300, 8'h21, 16'h0, mk_lo(0, 0, 24'h000111, 1, 1, 1),
                mk_lo(0, 0, 24'h000222, 1, 1, 0), 1'b1);
    lookup(32'h0060_0010, 8'h22, 2'd1, "R1");     // no global -> NOMATCH
    lookup(32'h0060_1010, 8'h21, 2'd1, "R4");

    // entries 3 and 4 overlap: lowest index decides
    write_entry(3'd4, 19'h00400, 8'h01, 16'h0, mk_lo(0, 0, 24'h000444, 1, 0, 0), 32'h0, 1'b0);
    lookup(32'h0080_0020, 8'h01, 2'd1, "R11");     // visible next cycle: INVALID
    write_entry(3'd3, 19'h00400, 8'h01, 16'h0, mk_lo(0, 0, 24'h000333, 1, 1, 0), 32'h0, 1'b0);
    lookup(32'h0080_0020, 8'h01, 2'd1, "R11");     // entry 3 wins

    // R9 back-pressure
    begin
      logic [2:0] fa; logic [35:0] pa_a; logic [2:0] fb; logic [35:0] pa_b;
      model(32'h0020_0123, 8'h05, 2'd1, fa, pa_a);
      model(32'h0040_2abc, 8'h77, 2'd1, fb, pa_b);
      @(negedge clk);
      rsp_ready = 1'b0; req_valid = 1'b1; req_va = 32'h0020_0123; req_asid = 8'h05; req_acc = 2'd1;
      @(posedge clk); @(negedge clk);
      check("R9", "valid held", rsp_valid, 1'b1);
      check("R9", "ready low", req_ready, 1'b0);
      req_va = 32'h0040_2abc; req_asid = 8'h77;
      @(posedge clk); @(negedge clk);
      check("R9", "held result", {rsp_fault, rsp_pa}, {fa, pa_a});
      rsp_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
      check("R9", "second result", {rsp_valid, rsp_fault, rsp_pa}, {1'b1, fb, pa_b});
      @(posedge clk); @(negedge clk);
      check("R9", "drained", rsp_valid, 1'b0);
    end

    // constrained random fill and lookups
    for (int r = 0; r < 12; r++) begin
      for (int i = 0; i < 8; i++) begin
        int k = $urandom_range(0, 5);
        logic [15:0] pm = (k == 0) ? 16'h0 : 16'((1 << k) - 1);
        logic [31:0] a = $urandom, b = $urandom;
        if ($urandom_range(0, 3) != 0) begin a[1] = 1'b1; b[1] = 1'b1; end
        write_entry(3'(i), 19'($urandom_range(0, 63)) << 5, 8'($urandom_range(0, 3)), pm, a, b, 1'b1);
      end
      for (int n = 0; n < 250; n++) begin
        int e = $urandom_range(0, 7);
        logic [31:0] va = $urandom;
        logic [7:0]  as = ($urandom_range(0, 3) != 0) ? m_asid[e] : 8'($urandom_range(0, 3));
        if ($urandom_range(0, 7) != 0) va[31:13] = m_vpn[e] ^ (19'($urandom) & {3'b0, m_pm[e]});
        lookup(va, as, 2'($urandom_range(0, 2)), "R2");
      end
    end
    summary();
  end

endmodule